// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a general-purpose up-counting timer that sits behind a small register port. The system clock passes through a programmable prescaler. Each prescaler tick advances a 16-bit counter. When the counter sits at the programmed limit value on a tick, it returns to zero and latches a limit event. A level interrupt follows that latched event whenever the interrupt enable is set. Software clears the event by writing a one to it.

Software controls the timer through a control word. The word holds a run bit, a two-bit tick source code, a wrap-on-limit bit, an interrupt enable and an 8-bit prescale field. A small controller with three states (HELD, PAUSED, COUNT) works out from the control word whether the counter may advance. HELD applies while the run bit is 0. PAUSED applies when run is 1 but the source code is unsupported or the wrap bit is clear. COUNT applies otherwise. The transitions are named in the RTL:
- ARM: HELD to PAUSED.
- START: HELD or PAUSED to COUNT.
- HALT: COUNT to PAUSED.
- DISARM: any state to HELD.

The next state is taken from the value being written, so a control write takes effect at the same edge that stores it.

Top module: `rct_timer`

## Requirements
- R1: After reset the control word reads 0x0000, the limit reads 0xFFFF, and the counter, capture (0x08) and event (0x11) registers read 0. The interrupt output is 0.
- R2: In state COUNT the prescaler fires once every P+1 clocks, where P is control bits [15:8]. After a control write that enters COUNT, the counter reads floor(N/(P+1)) N clocks later, until it reaches the limit.
- R3: A tick that finds the counter equal to the limit (address 0x04) loads 0 into the counter and sets event bit 1 at that same edge. The counter period is therefore limit+1 ticks.
- R4: While control bit 0 (run) is 0 the counter does not advance.
- R5: With run set, source codes 1 and 2 in control bits [2:1] count. Codes 0 and 3, or control bit 3 (wrap-on-limit) at 0, leave the counter frozen.
- R6: A control write (address 0x00) that changes run from 1 to 0 clears the counter and the event, and sets the limit to 0xFFFF. A control write with run already 0 changes no other register.
- R7: The interrupt output equals control bit 4 (enable) AND event bit 1.
- R8: Writing event address 0x11 with data bit 1 set clears the event. Data bit 1 at 0 leaves it unchanged. If a limit match happens in the same cycle, the set takes priority.
- R9: A write to the counter address 0x0C loads the count directly, and counting resumes from that value with a fresh prescaler phase.
- R10: Any write to the control word or the limit restarts the prescaler phase at that edge, using the new prescale value.
- R11: The capture address and unmapped addresses read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt: enable AND event |

## Verification
The bench sweeps prescale values 0 to 4 against limits 0 to 3, alternating the two supported source codes. It compares the counter, the event flag and the interrupt on every clock against floor(N/(P+1)) taken modulo limit+1. This sweep catches an off-by-one in the divisor, or a wrap that happens one tick early or late.

It also writes the limit in the middle of a prescale period, at the same value as before. A design that failed to restart the phase would then tick one clock too early. It preloads the counter and then forces a wrap. It performs a soft reset, and also a control write with run already 0. A design that reset on any run-0 write would lose the preloaded count and the limit.

The clear-on-one event is probed with bit 0 set and then bit 1 set. The interrupt is probed with the enable both off and on while the event is held. Any inverted or ignored bit therefore shows up at the irq pin.

// File: rtl/rct_pkg.sv
package rct_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_LIMIT = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CAPT  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_EVENT = 5'h11;

    localparam int RUN_BIT   = 0;
    localparam int SRC_LSB   = 1;
    localparam int WRAP_BIT  = 3;
    localparam int IEN_BIT   = 4;
    localparam int PSC_LSB   = 8;
    localparam int EV_LIMIT  = 1;

    typedef enum logic [1:0] {
        S_HELD   = 2'd0,
        S_PAUSED = 2'd1,
        S_COUNT  = 2'd2
    } state_e;

    function automatic logic src_supported(input logic [1:0] code);
        return (code == 2'd1) || (code == 2'd2);
    endfunction

endpackage

// File: rtl/rct_ctrl.sv
module rct_ctrl
    import rct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_d,
    input  logic [1:0] src_d,
    input  logic       wrap_d,
    output logic       cnt_en
);

    state_e state_q;
    state_e state_d;
    logic   cfg_ok;

    assign cfg_ok = src_supported(src_d) && wrap_d;

    // Next-state logic; control word values are those being stored this edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HELD: begin
                if (run_d && cfg_ok)      state_d = S_COUNT;   // START
                else if (run_d)           state_d = S_PAUSED;  // ARM
            end
            S_PAUSED: begin
                if (!run_d)               state_d = S_HELD;    // DISARM
                else if (cfg_ok)          state_d = S_COUNT;   // START
            end
            S_COUNT: begin
                if (!run_d)               state_d = S_HELD;    // DISARM
                else if (!cfg_ok)         state_d = S_PAUSED;  // HALT
            end
            default:                      state_d = S_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            S_COUNT: cnt_en = 1'b1;
            default: cnt_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/rct_prescaler.sv
module rct_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [PSC_W-1:0] div_m1,
    output logic             tick
);

    logic [PSC_W-1:0] phase_q;

    assign tick = en && !clr && (phase_q == div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 phase_q <= '0;
        else if (clr || !en || tick) phase_q <= '0;
        else                        phase_q <= phase_q + 1'b1;
    end

endmodule

// File: rtl/rct_counter.sv
module rct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match
);

    assign match = tick && !load && !sclr && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (sclr)   cnt_q <= '0;
        else if (load)   cnt_q <= load_val;
        else if (match)  cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/rct_timer.sv
module rct_timer
    import rct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 8,
    parameter int DATA_W = (CNT_W > PSC_W + 8) ? CNT_W : PSC_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int MODE_W = PSC_LSB + PSC_W;

    logic [MODE_W-1:0] mode_q;
    logic [MODE_W-1:0] mode_d;
    logic [CNT_W-1:0]  ref_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              evt_q;

    logic wr_mode, wr_ref, wr_cnt, wr_evt;
    logic soft_rst, cnt_en, tick, match, phase_clr;

    assign wr_mode  = bus_wr && (bus_addr == OFF_CTRL);
    assign wr_ref   = bus_wr && (bus_addr == OFF_LIMIT);
    assign wr_cnt   = bus_wr && (bus_addr == OFF_COUNT);
    assign wr_evt   = bus_wr && (bus_addr == OFF_EVENT);
    assign soft_rst = wr_mode && mode_q[RUN_BIT] && !bus_wdata[RUN_BIT];
    assign mode_d   = wr_mode ? bus_wdata[MODE_W-1:0] : mode_q;
    assign phase_clr = wr_mode || wr_ref || wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ref_q <= '1;
        else if (soft_rst) ref_q <= '1;
        else if (wr_ref)   ref_q <= bus_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              evt_q <= 1'b0;
        else if (soft_rst)                       evt_q <= 1'b0;
        else if (match)                          evt_q <= 1'b1;
        else if (wr_evt && bus_wdata[EV_LIMIT])  evt_q <= 1'b0;
    end

    rct_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_d  (mode_d[RUN_BIT]),
        .src_d  (mode_d[SRC_LSB +: 2]),
        .wrap_d (mode_d[WRAP_BIT]),
        .cnt_en (cnt_en)
    );

    rct_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cnt_en),
        .clr    (phase_clr),
        .div_m1 (mode_q[PSC_LSB +: PSC_W]),
        .tick   (tick)
    );

    rct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclr     (soft_rst),
        .load     (wr_cnt),
        .load_val (bus_wdata[CNT_W-1:0]),
        .tick     (tick),
        .limit    (ref_q),
        .cnt_q    (cnt_q),
        .match    (match)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL:  bus_rdata[MODE_W-1:0] = mode_q;
            OFF_LIMIT: bus_rdata[CNT_W-1:0]  = ref_q;
            OFF_COUNT: bus_rdata[CNT_W-1:0]  = cnt_q;
            OFF_EVENT: bus_rdata[EV_LIMIT]   = evt_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = mode_q[IEN_BIT] && evt_q;

endmodule

// File: rtl/rct_timer_checker.sv
module rct_timer_checker
    import rct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [4:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [MODE_W-1:0] mode_q,
    input logic [CNT_W-1:0]  ref_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              evt_q
);

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mode_q[IEN_BIT]);

    a_r3_event_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q) |-> ($past(cnt_q) == $past(ref_q)) && (cnt_q == '0));

    a_r4_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[RUN_BIT] && !bus_wr) |=> $stable(cnt_q));

    a_r5_bad_source_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q[SRC_LSB +: 2] == 2'd0 || mode_q[SRC_LSB +: 2] == 2'd3 || !mode_q[WRAP_BIT])
         && !bus_wr) |=> $stable(cnt_q));

    a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CTRL && mode_q[RUN_BIT] && !bus_wdata[RUN_BIT])
        |=> (cnt_q == '0) && !evt_q && (ref_q == '1));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0));

endmodule

bind rct_timer rct_timer_checker #(
    .CNT_W  (CNT_W),
    .MODE_W (MODE_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .mode_q    (mode_q),
    .ref_q     (ref_q),
    .cnt_q     (cnt_q),
    .evt_q     (evt_q)
);

// File: tb/rct_timer_bench.sv
module rct_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rct_timer u_rct_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // called at a falling edge; one rising edge commits the write
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic soft_reset();
        wr(5'h00, 16'h0001);
        wr(5'h00, 16'h0000);
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); chk("R1 control", v, 16'h0000);
        rd(5'h04, v); chk("R1 limit", v, 16'hFFFF);
        rd(5'h0C, v); chk("R1 counter", v, 16'h0000);
        rd(5'h08, v); chk("R1 capture", v, 16'h0000);
        rd(5'h11, v); chk("R1 event", v, 16'h0000);
        chk("R1 irq", irq, 1'b0);
        rd(5'h02, v); chk("R11 unmapped read", v, 16'h0000);

        // R2 R3 R7 sweep over prescale and limit
        for (int p = 0; p <= 4; p++) begin
            for (int r = 0; r <= 3; r++) begin
                int nmax;
                logic [15:0] mode;
                mode = {p[7:0], 8'h00} | (((p + r) % 2 == 0) ? 16'h001B : 16'h001D);
                nmax = (p + 1) * (r + 1) * 2 + 2;
                soft_reset();
                wr(5'h04, r[15:0]);
                wr(5'h00, mode);
                for (int n = 0; n <= nmax; n++) begin
                    int k;
                    if (n > 0) @(negedge clk);
                    k = n / (p + 1);
                    rd(5'h0C, v);
                    chk($sformatf("R2 R3 count p=%0d r=%0d n=%0d", p, r, n), v, k % (r + 1));
                    rd(5'h11, v);
                    chk($sformatf("R3 event p=%0d r=%0d n=%0d", p, r, n), v,
                        (k >= r + 1) ? 16'h0002 : 16'h0000);
                    chk($sformatf("R7 irq p=%0d r=%0d n=%0d", p, r, n), irq, (k >= r + 1));
                end
            end
        end

        // R7 enable off then on, event held while wrap bit is 0
        wr(5'h00, 16'h0003);
        rd(5'h11, v); chk("R7 event kept", v, 16'h0002);
        chk("R7 irq masked", irq, 1'b0);
        wr(5'h00, 16'h0013);
        chk("R7 irq enabled", irq, 1'b1);
        rd(5'h0C, v); idle(6); rd(5'h0C, v2);
        chk("R5 wrap bit 0 frozen", v2, v);

        // R8 clear on one
        wr(5'h11, 16'h0001);
        rd(5'h11, v); chk("R8 bit0 ignored", v, 16'h0002);
        chk("R8 irq still", irq, 1'b1);
        wr(5'h11, 16'h0002);
        rd(5'h11, v); chk("R8 cleared", v, 16'h0000);
        chk("R8 irq low", irq, 1'b0);

        // R5 unsupported source codes
        soft_reset();
        wr(5'h04, 16'h0003);
        wr(5'h00, 16'h0019);
        idle(10);
        rd(5'h0C, v); chk("R5 source 0", v, 16'h0000);
        wr(5'h00, 16'h001F);
        idle(10);
        rd(5'h0C, v); chk("R5 source 3", v, 16'h0000);

        // R4 held with otherwise valid config
        soft_reset();
        wr(5'h00, 16'h001A);
        idle(10);
        rd(5'h0C, v); chk("R4 held", v, 16'h0000);

        // R11 writes to capture ignored
        wr(5'h08, 16'hFFFF);
        rd(5'h08, v); chk("R11 capture write", v, 16'h0000);
        rd(5'h04, v); chk("R11 limit untouched", v, 16'hFFFF);
        rd(5'h0C, v); chk("R11 counter untouched", v, 16'h0000);

        // R9 preload with prescale 2
        soft_reset();
        wr(5'h04, 16'd100);
        wr(5'h00, 16'h021B);
        idle(4);
        rd(5'h0C, v); chk("R2 prescale 3 at n=4", v, 16'd1);
        wr(5'h0C, 16'd50);
        rd(5'h0C, v); chk("R9 preload", v, 16'd50);
        idle(5);
        rd(5'h0C, v); chk("R9 n=5", v, 16'd51);
        idle(2);
        rd(5'h0C, v); chk("R9 n=7", v, 16'd52);

        // R10 limit write restarts phase (phase is 1 here)
        wr(5'h04, 16'd100);
        idle(2);
        rd(5'h0C, v); chk("R10 phase restart n=2", v, 16'd52);
        idle(1);
        rd(5'h0C, v); chk("R10 phase restart n=3", v, 16'd53);
        wr(5'h00, 16'h001B);
        idle(4);
        rd(5'h0C, v); chk("R10 new prescale", v, 16'd57);

        // R3 forced wrap, then R6 soft reset
        wr(5'h0C, 16'd100);
        idle(1);
        rd(5'h0C, v); chk("R3 wrap to zero", v, 16'd0);
        rd(5'h11, v); chk("R3 event on wrap", v, 16'h0002);
        wr(5'h04, 16'h1234);
        wr(5'h00, 16'h0000);
        rd(5'h0C, v); chk("R6 counter cleared", v, 16'd0);
        rd(5'h11, v); chk("R6 event cleared", v, 16'h0000);
        rd(5'h04, v); chk("R6 limit restored", v, 16'hFFFF);
        rd(5'h00, v); chk("R6 control written", v, 16'h0000);

        // R6 write with run already 0 is not a reset
        wr(5'h04, 16'h0055);
        wr(5'h0C, 16'd7);
        wr(5'h00, 16'h0000);
        rd(5'h0C, v); chk("R6 no reset count", v, 16'd7);
        rd(5'h04, v); chk("R6 no reset limit", v, 16'h0055);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule